// File: doc/BRIEF.md
# I2C Bit-Level Line Sequencer

This block produces the individual conditions and data bits of a two-wire serial bus. It works on open-drain clock and data lines. A controller above it hands over one operation at a time: a start condition (which also serves as a repeated start), a stop condition, one written bit, or one read bit. The block spaces the line changes by a time unit taken from a programmable prescaler. It signals the end of each operation with a one-cycle pulse and returns the bit it sampled on a read.

The outputs never drive a line high. Each output is a pull-low request, which the pad ring turns into "drive 0" or "high impedance". Every operation is split into four phases, and each phase changes at most one line. So the clock and data lines never move in the same cycle, and a repeated start after a written 0 still shows data falling while the clock is high. The data input passes through a two-flop synchroniser before it is sampled.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `scl_pull_low` and `sda_pull_low` are all 0, and `rx_bit` is 0.
- R2: A pull output at 1 means the line is driven low; 0 means released. An idle block keeps both pull outputs unchanged between operations.
- R3: In no clock cycle do both `scl_pull_low` and `sda_pull_low` change value.
- R4: A start operation (code 3'b001) runs in this order: release data, release clock, pull data low while the clock is released, pull clock low. It finishes with both lines pulled low.
- R5: A stop operation (code 3'b010) runs in this order: pull clock low, pull data low, release clock, release data. It finishes with both lines released.
- R6: A write operation (code 3'b011) first sets data from `cmd_bit` (1 releases, 0 pulls low) while the clock is unchanged. It then releases the clock, holds, and pulls the clock low. Data stays as set throughout.
- R7: A read operation (code 3'b100) releases data and then runs the same clock pattern as a write. `rx_bit` takes the synchronised `sda_in` at the end of the second phase, which is the middle of the clock-high time. `sda_in` reaches that point two cycles late.
- R8: Phases 0 to 2 each last prescale+1 cycles and phase 3 lasts 2*(prescale+1) cycles. `busy` is high for 5*(prescale+1) cycles, then `done` is high for exactly one cycle. A prescale of 191 gives a 960-cycle bit, which is 100 kHz at 96 MHz.
- R9: An operation is accepted only while `busy` is low and `cmd_valid` is high with one of the four codes. Other codes, and any request made while busy, are ignored.
- R10: A start issued after a write of 0 releases data before the clock rises. A start condition (data pulled while the clock is released) therefore appears on the lines.
- R11: `prescale` is captured when an operation is accepted. Changing it while busy has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | PRESC_W | Time unit minus one, in system clocks |
| cmd_valid | input | 1 | Operation request |
| cmd | input | 3 | Operation code |
| cmd_bit | input | 1 | Bit to write |
| sda_in | input | 1 | Data line level from the pad |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rx_bit | output | 1 | Last bit sampled by a read |
| scl_pull_low | output | 1 | 1 drives clock line low, 0 releases it |
| sda_pull_low | output | 1 | 1 drives data line low, 0 releases it |

## Verification
The bench keeps the default prescale width of 8 bits. It runs operations at prescale 0, where every phase is a single cycle, so adjacent line changes are packed one cycle apart. It also runs at prescale 2, where each phase spans several cycles and a mid-phase request can be rejected. A write at prescale 191 confirms the 960-cycle bit. The prescale port is changed during an operation, which exposes any design that reloads it from the port instead of the captured value.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } op_e;

  // 1 = pull line low, 0 = release
  typedef struct packed {
    logic scl;
    logic sda;
  } pull_t;

  localparam int PHASE_W   = 2;
  localparam int LAST_PHASE = 3;

  function automatic logic op_known(input logic [2:0] code);
    return (code == OP_START) || (code == OP_STOP) ||
           (code == OP_WRITE) || (code == OP_READ);
  endfunction

endpackage

// File: rtl/i2cseq_sync.sv
module i2cseq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               load_first,
  input  logic               load_next,
  input  logic               long_phase,
  output logic               expire
);
  localparam int CNT_W = PRESC_W + 1;

  logic [PRESC_W-1:0] unit_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (load_first) begin
      unit_q <= prescale;
      cnt_q  <= {1'b0, prescale};
    end else if (load_next) begin
      // doubled phase lasts 2*(unit+1) cycles: reload 2*unit+1
      cnt_q <= long_phase ? {unit_q, 1'b1} : {1'b0, unit_q};
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/i2cseq_wave.sv
module i2cseq_wave
  import i2cseq_pkg::*;
(
  input  op_e                  op,
  input  logic [PHASE_W-1:0]   phase,
  input  logic                 wbit,
  input  pull_t                cur,
  output pull_t                nxt
);
  always_comb begin
    nxt = cur;
    case (op)
      OP_START: begin
        case (phase)
          2'd0:    nxt.sda = 1'b0;
          2'd1:    begin nxt.scl = 1'b0; nxt.sda = 1'b0; end
          2'd2:    begin nxt.scl = 1'b0; nxt.sda = 1'b1; end
          default: begin nxt.scl = 1'b1; nxt.sda = 1'b1; end
        endcase
      end
      OP_STOP: begin
        case (phase)
          2'd0:    nxt.scl = 1'b1;
          2'd1:    begin nxt.scl = 1'b1; nxt.sda = 1'b1; end
          2'd2:    begin nxt.scl = 1'b0; nxt.sda = 1'b1; end
          default: begin nxt.scl = 1'b0; nxt.sda = 1'b0; end
        endcase
      end
      OP_WRITE, OP_READ: begin
        nxt.sda = (op == OP_WRITE) ? ~wbit : 1'b0;
        case (phase)
          2'd0:    nxt.scl = cur.scl;
          2'd1:    nxt.scl = 1'b0;
          2'd2:    nxt.scl = 1'b0;
          default: nxt.scl = 1'b1;
        endcase
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
  import i2cseq_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd,
  input  logic               cmd_bit,
  input  logic               sda_in,
  output logic               busy,
  output logic               done,
  output logic               rx_bit,
  output logic               scl_pull_low,
  output logic               sda_pull_low
);
  logic               busy_q, done_q, rx_q, bit_q;
  op_e                op_q;
  logic [PHASE_W-1:0] phase_q;
  pull_t              pull_q;

  logic               sda_sync;
  logic               accept, expire, step, last;
  op_e                wave_op;
  logic [PHASE_W-1:0] wave_phase;
  logic               wave_bit;
  pull_t              pull_nxt;

  i2cseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_sync)
  );

  assign accept = !busy_q && cmd_valid && op_known(cmd);
  assign step   = busy_q && expire;
  assign last   = (phase_q == PHASE_W'(LAST_PHASE));

  i2cseq_timer #(.PRESC_W(PRESC_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .prescale   (prescale),
    .load_first (accept),
    .load_next  (step && !last),
    .long_phase (phase_q == PHASE_W'(LAST_PHASE - 1)),
    .expire     (expire)
  );

  assign wave_op    = accept ? op_e'(cmd) : op_q;
  assign wave_phase = accept ? '0 : phase_q + 1'b1;
  assign wave_bit   = accept ? cmd_bit : bit_q;

  i2cseq_wave u_wave (
    .op    (wave_op),
    .phase (wave_phase),
    .wbit  (wave_bit),
    .cur   (pull_q),
    .nxt   (pull_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= 1'b0;
      bit_q   <= 1'b0;
      op_q    <= OP_NONE;
      phase_q <= '0;
      pull_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= op_e'(cmd);
        bit_q   <= cmd_bit;
        phase_q <= '0;
        pull_q  <= pull_nxt;
      end else if (step) begin
        if (op_q == OP_READ && phase_q == PHASE_W'(1))
          rx_q <= sda_sync;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
          pull_q  <= pull_nxt;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign rx_bit       = rx_q;
  assign scl_pull_low = pull_q.scl;
  assign sda_pull_low = pull_q.sda;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
  parameter int PRESC_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [PRESC_W-1:0] prescale,
  input logic               cmd_valid,
  input logic               busy,
  input logic               done,
  input logic               rx_bit,
  input logic               scl_pull_low,
  input logic               sda_pull_low
);
  int busy_cycles;
  int unit_at_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cycles   <= 0;
      unit_at_start <= 0;
    end else if (busy) begin
      busy_cycles <= busy_cycles + 1;
    end else begin
      busy_cycles   <= 0;
      unit_at_start <= int'(prescale) + 1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !rx_bit && !scl_pull_low && !sda_pull_low));

  assert_one_line_moves_R3: assert property (@(posedge clk) disable iff (rst)
    !((scl_pull_low != $past(scl_pull_low)) && (sda_pull_low != $past(sda_pull_low))));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_op_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cycles == 5 * unit_at_start));

  assert_accept_idle_only_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (busy || done));
endmodule

bind i2c_bit_sequencer i2cseq_checker #(.PRESC_W(PRESC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .prescale     (prescale),
  .cmd_valid    (cmd_valid),
  .busy         (busy),
  .done         (done),
  .rx_bit       (rx_bit),
  .scl_pull_low (scl_pull_low),
  .sda_pull_low (sda_pull_low)
);

// File: tb/i2c_bit_sequencer_tb.sv
module i2c_bit_sequencer_tb;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] prescale = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic          cmd_bit = 1'b0;
  logic          sda_in = 1'b1;
  logic          busy, done, rx_bit, scl_pull_low, sda_pull_low;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  i2c_bit_sequencer #(.PRESC_W(PW)) u_dut (
    .clk(clk), .rst(rst), .prescale(prescale), .cmd_valid(cmd_valid),
    .cmd(cmd), .cmd_bit(cmd_bit), .sda_in(sda_in), .busy(busy), .done(done),
    .rx_bit(rx_bit), .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_busy, m_done, m_rx, m_op, m_bit, m_phase, m_left, m_unit, m_scl, m_sda;
  bit sda_hist[$];

  // returns {scl,sda} pull values for a phase, from the requirement text
  function automatic int pulls(int op, int ph, int b, int scl, int sda);
    int s = scl, d = sda;
    case (op)
      1: case (ph) 0: d = 0; 1: begin s = 0; d = 0; end
                   2: begin s = 0; d = 1; end default: begin s = 1; d = 1; end endcase
      2: case (ph) 0: s = 1; 1: begin s = 1; d = 1; end
                   2: begin s = 0; d = 1; end default: begin s = 0; d = 0; end endcase
      3, 4: begin
        d = (op == 3) ? (b ? 0 : 1) : 0;
        if (ph == 1 || ph == 2) s = 0;
        if (ph == 3) s = 1;
      end
      default: ;
    endcase
    return s * 2 + d;
  endfunction

  always @(posedge clk) begin
    int p;
    if (rst) begin
      m_busy = 0; m_done = 0; m_rx = 0; m_op = 0; m_bit = 0; m_phase = 0;
      m_left = 0; m_unit = 1; m_scl = 0; m_sda = 0;
      sda_hist = {};
      sda_hist.push_front(1'b1);
      sda_hist.push_front(1'b1);
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (cmd_valid && cmd >= 3'd1 && cmd <= 3'd4) begin
          m_busy = 1; m_op = int'(cmd); m_bit = int'(cmd_bit); m_phase = 0;
          m_unit = int'(prescale) + 1; m_left = m_unit;
          p = pulls(m_op, 0, m_bit, m_scl, m_sda); m_scl = p / 2; m_sda = p % 2;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_op == 4 && m_phase == 1) m_rx = int'(sda_hist[1]);
          if (m_phase == 3) begin
            m_busy = 0; m_done = 1;
          end else begin
            m_phase++;
            m_left = (m_phase == 3) ? 2 * m_unit : m_unit;
            p = pulls(m_op, m_phase, m_bit, m_scl, m_sda); m_scl = p / 2; m_sda = p % 2;
          end
        end
      end
      sda_hist.push_front(sda_in);
      if (sda_hist.size() > 4) void'(sda_hist.pop_back());
    end
  end

  // ---------------- per-cycle compare and line monitors ----------------
  int start_seen = 0;
  int both_moved = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  always @(negedge clk) begin
    string lt;
    case (m_op) 1: lt = "R4"; 2: lt = "R5"; 3: lt = "R6"; 4: lt = "R7"; default: lt = "R2"; endcase
    check(int'(scl_pull_low) == m_scl, {lt, " scl pull"}, int'(scl_pull_low), m_scl);
    check(int'(sda_pull_low) == m_sda, {lt, " sda pull"}, int'(sda_pull_low), m_sda);
    check(int'(busy) == m_busy, "R9 busy", int'(busy), m_busy);
    check(int'(done) == m_done, "R8 done", int'(done), m_done);
    check(int'(rx_bit) == m_rx, "R7 rx_bit", int'(rx_bit), m_rx);
    if (!rst) begin
      if (sda_pull_low && !prev_sda && !scl_pull_low) start_seen++;
      if ((sda_pull_low != prev_sda) && (scl_pull_low != prev_scl)) both_moved++;
    end
    prev_scl = scl_pull_low;
    prev_sda = sda_pull_low;
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [2:0] code, input logic b);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd = code; cmd_bit = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n, s0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!busy && !done && !scl_pull_low && !sda_pull_low && !rx_bit, "R1 reset state",
          int'({busy, done, scl_pull_low, sda_pull_low, rx_bit}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !scl_pull_low && !sda_pull_low, "R1 after reset",
          int'({busy, scl_pull_low, sda_pull_low}), 0);

    // R9: unknown codes ignored
    cmd = 3'd7; cmd_valid = 1'b1; @(negedge clk);
    cmd = 3'd0; @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R9 unknown code ignored", int'(busy), 0);

    // R4: start from idle, prescale 2
    prescale = 8'd2;
    s0 = start_seen;
    issue(3'd1, 1'b0); wait_done();
    check(start_seen == s0 + 1, "R4 start condition seen", start_seen - s0, 1);
    check(scl_pull_low && sda_pull_low, "R4 lines after start",
          int'({scl_pull_low, sda_pull_low}), 3);

    // R6: writes, then R10 repeated start after a 0
    issue(3'd3, 1'b1); wait_done();
    check(!sda_pull_low, "R6 write 1 releases data", int'(sda_pull_low), 0);
    issue(3'd3, 1'b0); wait_done();
    check(sda_pull_low && scl_pull_low, "R6 write 0 pulls data", int'({scl_pull_low, sda_pull_low}), 3);
    s0 = start_seen;
    issue(3'd1, 1'b0); wait_done();
    check(start_seen == s0 + 1, "R10 repeated start visible", start_seen - s0, 1);

    // R7: reads with data 0 and 1
    sda_in = 1'b0;
    issue(3'd4, 1'b0); wait_done();
    check(rx_bit == 1'b0, "R7 read zero", int'(rx_bit), 0);
    sda_in = 1'b1;
    issue(3'd4, 1'b0); wait_done();
    check(rx_bit == 1'b1, "R7 read one", int'(rx_bit), 1);

    // R9 and R11: request and prescale change while busy are ignored
    issue(3'd3, 1'b0);
    @(negedge clk);
    prescale = 8'd9;
    cmd = 3'd2; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0; cmd = 3'd0;
    wait_done();
    check(sda_pull_low && scl_pull_low, "R9 stop request ignored while busy",
          int'({scl_pull_low, sda_pull_low}), 3);
    prescale = 8'd2;

    // R5: stop releases both lines
    issue(3'd2, 1'b0); wait_done();
    @(negedge clk);
    check(!scl_pull_low && !sda_pull_low, "R5 lines released after stop",
          int'({scl_pull_low, sda_pull_low}), 0);
    check(!busy, "R2 idle lines stay", int'(busy), 0);

    // R8: minimum prescale sequence and length
    prescale = 8'd0;
    issue(3'd1, 1'b0); wait_done();
    issue(3'd3, 1'b0); wait_done();
    issue(3'd4, 1'b0); wait_done();
    issue(3'd2, 1'b0); wait_done();

    // R8: 960-cycle bit at prescale 191
    prescale = 8'd191;
    @(negedge clk);
    cmd = 3'd3; cmd_bit = 1'b1; cmd_valid = 1'b1;
    n = 0;
    @(posedge clk); n++;
    @(negedge clk); cmd_valid = 1'b0;
    while (!done) begin @(posedge clk); n++; @(negedge clk); end
    check(n == 961, "R8 bit length at prescale 191", n, 961);

    check(both_moved == 0, "R3 lines never move together", both_moved, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule